// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a clause-22 management master for an external Ethernet PHY. Software programs a clock divider once. It then writes one 32-bit command word, and that single write carries out a whole management transaction. The block produces the management clock (MDC) from the system clock. It sends a 32-bit run of ones on the data line, then shifts out the command word most significant bit first. For reads, it releases the data line during turnaround so the PHY can drive the 16 data bits back.

When the frame ends, the returned data replaces the low half of the command word. A completion flag is raised at a fixed bit of a 32-bit event word, and software clears it by writing a one to that bit. The command word is laid out as the PHY expects it on the wire:

- bits 31:30: start code
- bits 29:28: opcode
- bits 27:23: PHY address
- bits 22:18: register address
- bits 17:16: turnaround
- bits 15:0: data

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After synchronous reset, MDC is low, the data line is released (output enable 0), the command word reads 0 and the event word reads 0.
- R2: With a nonzero divider D, MDC starts low in the cycle after an accepted command write. Each half period lasts D system clocks, the period is 2*D, and a frame holds exactly 64 MDC periods, after which MDC stays low.
- R3: During the first 32 MDC periods of every frame, the block drives the data line with output enable 1 and value 1. The preamble is never skipped.
- R4: Period k, for k from 32 to 63, carries command word bit 63-k, driven with output enable 1. The bit changes only at the start of a period.
- R5: When opcode bits 29:28 equal 2'b10 (read), the output enable is 0 for periods 46 through 63, which are the turnaround and data periods.
- R6: On a read, the block samples the data line at each rising MDC edge of periods 48 to 63, most significant bit first. When the frame completes, the 16 sampled bits replace command word bits 15:0, and bits 31:16 keep their written value. On a non-read, the command word is unchanged at completion.
- R7: Event bit 23 rises on the system clock edge that ends the last MDC period, which is 128*D clocks after the clock edge that accepted the write.
- R8: A write to the event word with bit 23 set clears event bit 23. A write with bit 23 clear leaves it set. If completion and a clear occur on the same edge, the bit ends up set.
- R9: A command write that arrives while a frame is in progress is ignored. The current frame keeps its bits and timing, and the command word is not reloaded.
- R10: With divider 0, MDC stays low and a command write neither starts a frame nor loads the command word.
- R11: Only opcode 2'b10 releases the data line. Opcodes 2'b00, 2'b01 and 2'b11 drive all 64 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Write strobe for the command word |
| cmd_wr_val | input | 32 | Command word value to write |
| div_wr_en | input | 1 | Write strobe for the divider |
| div_wr_val | input | DIV_W | MDC half period in system clocks |
| evt_wr_en | input | 1 | Write strobe for the event word |
| evt_wr_val | input | 32 | Write-one-to-clear mask for the event word |
| cmd_rd | output | 32 | Current command word, including read data after a read |
| evt_rd | output | 32 | Event word; only bit 23 is implemented |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
Every result has a fixed latency, counted from the clock edge that accepts the command write.

| Result | Due on clock edge |
|---|---|
| Rising MDC edge of period k | (2k+1)*D |
| Completion flag and returned data | 128*D |

The bench records the time of that acceptance edge and derives every expected instant from it. It compares each observed rising MDC edge against that schedule on the falling system clock edge that follows. It samples the event and command words on the falling edges just before and just after edge 128*D, which also pins down the ordering of a simultaneous clear.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Frame geometry fixed by the management protocol
    localparam int PREAMBLE_BITS = 32;
    localparam int CMD_BITS      = 32;
    localparam int FRAME_BITS    = PREAMBLE_BITS + CMD_BITS;
    localparam int IDX_W         = $clog2(FRAME_BITS);
    localparam int HDR_BITS      = 14;                          // start+op+phy+reg
    localparam int RELEASE_IDX   = PREAMBLE_BITS + HDR_BITS;    // first turnaround period
    localparam int SAMPLE_IDX    = RELEASE_IDX + 2;             // first data period
    localparam int RDATA_W       = 16;
    localparam int EVT_BIT       = 23;
    localparam logic [31:0] EVT_MASK = 32'h1 << EVT_BIT;

    typedef enum logic [1:0] {
        MOP_RSVD0 = 2'b00,
        MOP_WRITE = 2'b01,
        MOP_READ  = 2'b10,
        MOP_RSVD3 = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]          st;
        mdio_op_e            op;
        logic [4:0]          phy;
        logic [4:0]          regad;
        logic [1:0]          ta;
        logic [RDATA_W-1:0]  data;
    } mdio_cmd_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_SHIFT
    } eng_state_e;

    function automatic logic cmd_is_read(input mdio_cmd_t c);
        return c.op == MOP_READ;
    endfunction

    // Value driven during frame period idx
    function automatic logic frame_bit(input mdio_cmd_t c, input logic [IDX_W-1:0] idx);
        logic [CMD_BITS-1:0] w;
        int                  p;
        w = c;
        if (int'(idx) < PREAMBLE_BITS) begin
            return 1'b1;
        end
        p = FRAME_BITS - 1 - int'(idx);
        return w[p[4:0]];
    endfunction

    // Periods during which a read leaves the line to the PHY
    function automatic logic line_released(input logic rd, input logic [IDX_W-1:0] idx);
        return rd && (int'(idx) >= RELEASE_IDX);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    assign tick     = run && (cnt_q == half_len - DIV_W'(1));
    assign rise_stb = tick && !mdc_q;
    assign fall_stb = tick && mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R2: the half-period counter never passes the programmed length
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < half_len));

    // R2: a rising strobe is followed by MDC high
    a_r2_rise_sets_mdc: assert property (@(posedge clk) disable iff (rst)
        rise_stb |=> mdc_q);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  mdio_cmd_t          start_cmd,
    input  logic [DIV_W-1:0]   start_div,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic [DIV_W-1:0]   run_div,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done,
    output logic               done_rd,
    output logic [RDATA_W-1:0] rd_val
);

    eng_state_e          state_q;
    mdio_cmd_t           cmd_q;
    logic [DIV_W-1:0]    div_q;
    logic [IDX_W-1:0]    idx_q;
    logic [RDATA_W-1:0]  rsh_q;
    logic                last_bit;
    logic                shifting;
    logic                rd_frame;

    assign shifting = (state_q == ENG_SHIFT);
    assign rd_frame = cmd_is_read(cmd_q);
    assign last_bit = (int'(idx_q) == FRAME_BITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            cmd_q   <= '0;
            div_q   <= '0;
            idx_q   <= '0;
            rsh_q   <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        state_q <= ENG_SHIFT;
                        cmd_q   <= start_cmd;
                        div_q   <= start_div;
                        idx_q   <= '0;
                        rsh_q   <= '0;
                    end
                end
                ENG_SHIFT: begin
                    if (rise_stb && (int'(idx_q) >= SAMPLE_IDX)) begin
                        rsh_q <= {rsh_q[RDATA_W-2:0], mdio_i};
                    end
                    if (fall_stb) begin
                        if (last_bit) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign busy    = shifting;
    assign run_div = div_q;
    assign done    = shifting && fall_stb && last_bit;
    assign done_rd = rd_frame;
    assign rd_val  = rsh_q;
    assign mdio_oe = shifting && !line_released(rd_frame, idx_q);
    assign mdio_o  = shifting ? frame_bit(cmd_q, idx_q) : 1'b1;

    // R3: preamble periods drive a one
    a_r3_preamble_ones: assert property (@(posedge clk) disable iff (rst)
        (shifting && (int'(idx_q) < PREAMBLE_BITS)) |-> (mdio_oe && mdio_o));

    // R5: a read releases the line from turnaround onward
    a_r5_read_release: assert property (@(posedge clk) disable iff (rst)
        (shifting && rd_frame && (int'(idx_q) >= RELEASE_IDX)) |-> !mdio_oe);

    // R2: a frame runs with a nonzero half period
    a_r2_nonzero_div: assert property (@(posedge clk) disable iff (rst)
        shifting |-> (div_q != '0));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr_en,
    input  logic [31:0]      cmd_wr_val,
    input  logic             div_wr_en,
    input  logic [DIV_W-1:0] div_wr_val,
    input  logic             evt_wr_en,
    input  logic [31:0]      evt_wr_val,
    output logic [31:0]      cmd_rd,
    output logic [31:0]      evt_rd,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    logic [CMD_BITS-1:0] cmd_q;
    logic [DIV_W-1:0]    div_q;
    logic                evt_q;
    logic                start;
    logic                busy;
    logic                done;
    logic                done_rd;
    logic [RDATA_W-1:0]  rd_val;
    logic [DIV_W-1:0]    run_div;
    logic                rise_stb;
    logic                fall_stb;
    logic [31:0]         evt_hit;
    logic                evt_clr;

    assign start   = cmd_wr_en && !busy && (div_q != '0);
    assign evt_hit = evt_wr_val & EVT_MASK;
    assign evt_clr = evt_wr_en && (|evt_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            div_q <= '0;
            evt_q <= 1'b0;
        end else begin
            if (div_wr_en) begin
                div_q <= div_wr_val;
            end
            if (start) begin
                cmd_q <= cmd_wr_val;
            end else if (done && done_rd) begin
                cmd_q[RDATA_W-1:0] <= rd_val;
            end
            if (done) begin
                evt_q <= 1'b1;
            end else if (evt_clr) begin
                evt_q <= 1'b0;
            end
        end
    end

    assign cmd_rd = cmd_q;
    assign evt_rd = evt_q ? EVT_MASK : 32'h0;

    mdio_frame_engine #(.DIV_W(DIV_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_cmd (mdio_cmd_t'(cmd_wr_val)),
        .start_div (div_q),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .run_div   (run_div),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .done_rd   (done_rd),
        .rd_val    (rd_val)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half_len (run_div),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    // R10: with no frame in progress MDC rests low
    a_r10_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R10: a zero divider never lets a frame begin
    a_r10_zero_div_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy && (div_q == '0)) |=> !busy);

    // R9: a write during a frame leaves the upper command bits alone
    a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr_en) |=> $stable(cmd_q[CMD_BITS-1:RDATA_W]));

    // R8: completion wins over a same-edge clear
    a_r8_done_sets_event: assert property (@(posedge clk) disable iff (rst)
        done |=> evt_rd[EVT_BIT]);

endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;

    localparam int  CLK_PERIOD = 10;
    localparam int  DIV_W      = 6;
    localparam logic [31:0] EVT = 32'h0080_0000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_wr_en = 1'b0;
    logic [31:0]      cmd_wr_val = '0;
    logic             div_wr_en = 1'b0;
    logic [DIV_W-1:0] div_wr_val = '0;
    logic             evt_wr_en = 1'b0;
    logic [31:0]      evt_wr_val = '0;
    logic [31:0]      cmd_rd;
    logic [31:0]      evt_rd;
    logic             mdc;
    logic             mdio_o;
    logic             mdio_oe;
    logic             mdio_i;

    int  n_tests = 0;
    int  n_fail  = 0;

    // Frame context shared with the monitor and the PHY model
    logic [31:0] cur_word = '0;
    logic        cur_rd   = 1'b0;
    logic [15:0] phy_word = '0;
    int          cur_d    = 1;
    time         t0       = 0;
    int          rise_cnt = 0;
    int          per_err  = 0;
    int          pre_err  = 0;
    int          bit_err  = 0;
    int          oe_err   = 0;
    logic        prev_mdc = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctrl #(.DIV_W(DIV_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_wr_val (cmd_wr_val),
        .div_wr_en  (div_wr_en),
        .div_wr_val (div_wr_val),
        .evt_wr_en  (evt_wr_en),
        .evt_wr_val (evt_wr_val),
        .cmd_rd     (cmd_rd),
        .evt_rd     (evt_rd),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i)
    );

    // PHY model: presents read data bit 15..0 ahead of rising edges 48..63
    assign mdio_i = (cur_rd && rise_cnt >= 48 && rise_cnt < 64) ? phy_word[63 - rise_cnt] : 1'b1;

    // Monitor of every rising MDC edge
    always @(negedge clk) begin
        if (mdc && !prev_mdc) begin
            if (rise_cnt < 64) begin
                if ($time != t0 + time'((2 * rise_cnt + 1) * cur_d * CLK_PERIOD + CLK_PERIOD / 2))
                    per_err++;
                if (rise_cnt < 32) begin
                    if (!(mdio_oe === 1'b1 && mdio_o === 1'b1)) pre_err++;
                end else if (cur_rd && rise_cnt >= 46) begin
                    if (mdio_oe !== 1'b0) oe_err++;
                end else begin
                    if (mdio_oe !== 1'b1 || mdio_o !== cur_word[63 - rise_cnt]) bit_err++;
                end
            end
            rise_cnt++;
        end
        prev_mdc = mdc;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    task automatic set_div(input int d);
        @(negedge clk);
        div_wr_en  = 1'b1;
        div_wr_val = DIV_W'(d);
        @(negedge clk);
        div_wr_en  = 1'b0;
    endtask

    task automatic do_frame(input logic [31:0] w, input logic [15:0] pv, input int d,
                            input bit clash_clr, input bit poke);
        time t_pre;
        logic [31:0] exp_cmd;
        cur_word = w;
        cur_rd   = (w[29:28] == 2'b10);
        phy_word = pv;
        cur_d    = d;
        rise_cnt = 0;
        per_err  = 0;
        pre_err  = 0;
        bit_err  = 0;
        oe_err   = 0;
        @(negedge clk);
        cmd_wr_en  = 1'b1;
        cmd_wr_val = w;
        @(posedge clk);
        t0 = $time;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        if (poke) begin
            repeat (3 * d) @(negedge clk);
            cmd_wr_en  = 1'b1;
            cmd_wr_val = ~w;
            @(negedge clk);
            cmd_wr_en  = 1'b0;
        end
        t_pre = t0 + time'((128 * d - 1) * CLK_PERIOD + CLK_PERIOD / 2);
        while ($time < t_pre) @(negedge clk);
        chk("R7 event low before last edge", evt_rd, 32'h0);
        chk(poke ? "R9 command word kept during frame" : "R4 command word held during frame", cmd_rd, w);
        if (clash_clr) begin
            evt_wr_en  = 1'b1;
            evt_wr_val = EVT;
        end
        @(negedge clk);
        evt_wr_en = 1'b0;
        chk(clash_clr ? "R8 completion wins over clear" : "R7 event at 128*D", evt_rd, EVT);
        exp_cmd = cur_rd ? {w[31:16], pv} : w;
        chk(cur_rd ? "R6 read data merged" : "R6 non-read leaves word", cmd_rd, exp_cmd);
        chk("R2 rising edge count", rise_cnt, 64);
        chk("R2 rising edge timing errors", per_err, 0);
        chk("R2 MDC low after frame", {31'h0, mdc}, 32'h0);
        chk("R3 preamble errors", pre_err, 0);
        chk(cur_rd ? "R4 header bit errors" : "R11 full-drive bit errors", bit_err, 0);
        if (cur_rd) chk("R5 release errors", oe_err, 0);
        // write with bit 23 clear must not clear
        @(negedge clk);
        evt_wr_en  = 1'b1;
        evt_wr_val = ~EVT;
        @(negedge clk);
        evt_wr_en  = 1'b0;
        chk("R8 zero at bit 23 keeps event", evt_rd, EVT);
        evt_wr_en  = 1'b1;
        evt_wr_val = EVT;
        @(negedge clk);
        evt_wr_en  = 1'b0;
        chk("R8 one at bit 23 clears event", evt_rd, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 MDC in reset", {31'h0, mdc}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 MDC after reset", {31'h0, mdc}, 32'h0);
        chk("R1 output enable after reset", {31'h0, mdio_oe}, 32'h0);
        chk("R1 command word after reset", cmd_rd, 32'h0);
        chk("R1 event word after reset", evt_rd, 32'h0);

        // R10: divider is zero out of reset
        rise_cnt = 0;
        @(negedge clk);
        cmd_wr_en  = 1'b1;
        cmd_wr_val = mk_word(2'b10, 5'd3, 5'd1, 16'h0);
        @(negedge clk);
        cmd_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk("R10 no MDC edges with zero divider", rise_cnt, 0);
        chk("R10 command word not loaded", cmd_rd, 32'h0);
        chk("R10 no event with zero divider", evt_rd, 32'h0);

        // Sweep of dividers and all four opcodes
        for (int di = 0; di < 4; di++) begin
            int d;
            d = (di == 3) ? 5 : di + 1;
            set_div(d);
            for (int op = 0; op < 4; op++) begin
                logic [31:0] w;
                logic [15:0] pv;
                w  = mk_word(op[1:0], 5'((d * 7 + op * 3) % 32), 5'((d * 5 + op * 11) % 32),
                             16'hA5C3 ^ 16'((d << 8) | op));
                pv = 16'h3C96 ^ 16'((op << 12) | (d << 4) | d);
                do_frame(w, pv, d, 1'b0, 1'b0);
            end
        end

        // R8: clear on the completion edge
        set_div(2);
        do_frame(mk_word(2'b01, 5'd17, 5'd4, 16'h1234), 16'h0, 2, 1'b1, 1'b0);

        // R9: write arriving mid-frame
        set_div(3);
        do_frame(mk_word(2'b10, 5'd9, 5'd30, 16'hFFFF), 16'hB00B, 3, 1'b0, 1'b1);

        // Read returning extreme patterns
        set_div(1);
        do_frame(mk_word(2'b10, 5'd31, 5'd0, 16'h5555), 16'hFFFF, 1, 1'b0, 1'b0);
        do_frame(mk_word(2'b10, 5'd0, 5'd31, 16'hAAAA), 16'h0000, 1, 1'b0, 1'b0);

        // R10: divider set back to zero blocks a new write
        set_div(0);
        begin
            logic [31:0] keep;
            keep     = cmd_rd;
            rise_cnt = 0;
            @(negedge clk);
            cmd_wr_en  = 1'b1;
            cmd_wr_val = 32'h6DEA_D001;
            @(negedge clk);
            cmd_wr_en = 1'b0;
            repeat (20) @(negedge clk);
            chk("R10 zero divider ignores write", cmd_rd, keep);
            chk("R10 MDC held low", rise_cnt, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule